// File: doc/BRIEF.md
# Codec Boot Sequencer

This block brings an audio codec chip out of reset and loads its configuration over a two-wire serial bus. It does not toggle the bus wires itself: it hands one byte-level command at a time (start, stop, write a byte, read a byte with or without acknowledge) to a separate bus master engine. The engine ends each command with a single-cycle done pulse and, on reads, returns the byte it received.

The chip exposes three register spaces, and each has its own framing. The direct control registers take a 16-bit value. DSP memory holds 20-bit words and is reached through a six-byte command preamble. The codec registers have a 16-bit address and 16-bit data. After every verified write the sequencer reads the location back and compares the result. A fixed boot script runs once after reset. It holds the chip in reset, lets it settle, writes the control word, selects and confirms the DSP application, programs the main I/O word and then loads a list of codec registers. The script differs between encode mode and decode mode. The sequencer stops at the first mismatch and shows an error code. All waits are whole milliseconds, counted by a tick divider whose period is a parameter.

Top module: `codec_boot_seq`

## Requirements
- R1: After reset is released, `chipRstOut` stays high for RESET_MS milliseconds and is then low for SETTLE_MS milliseconds before the first command. One millisecond is CYC_PER_MS clock cycles. No bus command is issued while `chipRstOut` is high.
- R2: The script is chosen by the level of `modeSel` while `rst` is high: 0 selects encode and 1 selects decode. Changes to `modeSel` after reset has been released have no effect.
- R3: Command operation codes on `busCmdOp` are: 1 start (also used for a repeated start), 2 stop, 3 write `busCmdByte`, 4 read with acknowledge, 5 read with no acknowledge. `busCmdValid`, `busCmdOp` and `busCmdByte` hold steady until `busCmdDone` pulses.
- R4: A control write sends start, 0x3C, sub-address, data high, data low, stop. A control read sends start, 0x3C, sub-address, start, 0x3D, read-ack, read-nack, stop. A readback mismatch gives error code 1.
- R5: A DSP write sends start, 0x3C, 0x68, 0xE0, 0x00, 0x00, 0x01, address high, address low, 0x00, the data bits 19..16 as one byte, data bits 15..8, data bits 7..0, stop.
- R6: A DSP read sends start, 0x3C, 0x68, 0xC0, 0x00, 0x00, 0x01, address high, address low, stop. It then sends start, 0x3C, 0x69, start, 0x3D, three read-acks, a read-nack and stop. The first byte read is discarded, and only the low nibble of the second byte is kept as data bits 19..16.
- R7: A codec write sends start, 0x3C, 0x6C, address high, address low, data high, data low, stop. A codec read sends start, 0x3C, 0x6C, address high, address low, stop. It then sends start, 0x3C, 0x6D, start, 0x3D, read-ack, read-nack, stop. A mismatch gives error code 3.
- R8: The script steps, in order, are:
  - control 0x6A is written with 0x8C00 and verified;
  - DSP 0x07F6 is written with the application code (0x40 for encode, 0x0C for decode) and verified;
  - DSP 0x07F7 is checked;
  - DSP 0x07F1 is written;
  - DSP 0x07F1 is checked;
  - codec registers are written and verified.
  
  The encode codec list is (0x0000,0x2206), (0x0008,0x0000), (0x0011,0x0000). The decode codec list is (0x0000,0x2207), (0x0006,0x0000), (0x0007,0x4000), (0x0008,0x0000), (0x000E,0x0000), (0x0010,0x7F00), (0x0011,0x0000).
- R9: A failed readback of the application select word gives error 2. After that step there is a 200 ms wait. A read of 0x07F7 that does not return the application code gives error 4.
- R10: The main I/O word (0x09 for encode, 0x11 for decode) is written with no verify read. A 200 ms wait follows. Its readback must then equal the written value with bit 0 cleared (0x08 or 0x10), or error 5 is raised.
- R11: A 20 ms wait separates the end of the control step from the first DSP command.
- R12: On the first mismatch no further command is issued, `errCode` holds the code and `done` goes high. When the script completes, `done` goes high with `errCode` equal to 0. Both then stay unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 1 | Script select sampled during reset: 0 encode, 1 decode |
| busCmdValid | output | 1 | A command is presented to the bus engine |
| busCmdOp | output | 3 | Command operation code |
| busCmdByte | output | 8 | Byte to transmit for write commands |
| busCmdDone | input | 1 | One-cycle pulse: engine finished the current command |
| busRdByte | input | 8 | Byte received by a read command, valid with busCmdDone |
| chipRstOut | output | 1 | Active-high reset to the codec chip |
| errCode | output | 3 | 0 none, 1 control, 2 DSP verify, 3 codec, 4 application check, 5 main I/O check |
| done | output | 1 | Script finished or halted |

## Verification
The hardest behaviour to reach from the ports is a halt deep in the script, such as a failure on the last codec register of the decode list. Reaching it needs a complete, correctly framed conversation up to that point. The bench therefore plays the chip. It parses every frame into a small register model, returns DSP reads with a junk first byte and a set upper nibble, and can corrupt the readback of one chosen location. It then sweeps that corruption over every verified location in both scripts. For each case it checks that the command stream stops exactly after the failing read and that the matching error code is shown.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_START  = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_RDACK  = 3'd4,
    OP_RDNACK = 3'd5
  } busop_e;

  typedef enum logic [2:0] {
    TX_CTRL_WR, TX_CTRL_RD, TX_DSP_WR, TX_DSP_RD, TX_CODEC_WR, TX_CODEC_RD
  } txkind_e;

  typedef enum logic [1:0] {ST_WRV, ST_WR, ST_CHK} stepop_e;
  typedef enum logic [1:0] {SP_CTRL, SP_DSP, SP_CODEC} space_e;

  typedef struct packed {
    logic        start;
    txkind_e     kind;
    logic [15:0] addr;
    logic [19:0] data;
  } txnreq_t;

  localparam logic [7:0] DEV_WR    = 8'h3C;
  localparam logic [7:0] DEV_RD    = 8'h3D;
  localparam logic [7:0] SUB_DSP   = 8'h68;
  localparam logic [7:0] SUB_DSPRD = 8'h69;
  localparam logic [7:0] SUB_COD   = 8'h6C;
  localparam logic [7:0] SUB_CODRD = 8'h6D;
endpackage

// File: rtl/codec_ms_timer.sv
module codec_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MS_W       = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] loadMs,
  output logic            expired
);
  localparam int CYC_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

  logic [MS_W-1:0]  msLeft;
  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      msLeft <= '0;
      cyc    <= '0;
    end else if (load) begin
      msLeft <= loadMs;
      cyc    <= '0;
    end else if (msLeft != '0) begin
      if (cyc == CYC_W'(CYC_PER_MS - 1)) begin
        cyc    <= '0;
        msLeft <= msLeft - 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  assign expired = (msLeft == '0);
endmodule

// File: rtl/codec_frame_dp.sv
module codec_frame_dp
  import cfgseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  txnreq_t     req,
  output logic        txnDone,
  output logic        rdMatch,
  output logic        busCmdValid,
  output logic [2:0]  busCmdOp,
  output logic [7:0]  busCmdByte,
  input  logic        busCmdDone,
  input  logic [7:0]  busRdByte
);
  logic        busy;
  txkind_e     curKind;
  logic [15:0] curAddr;
  logic [19:0] curData;
  logic [4:0]  idx;
  logic [23:0] rdShift;
  busop_e      cmdOp;
  logic [7:0]  cmdByte;
  logic        cmdLast;
  logic [7:0]  ah, al;

  assign ah = curAddr[15:8];
  assign al = curAddr[7:0];

  always_comb begin
    cmdOp   = OP_WRITE;
    cmdByte = 8'h00;
    cmdLast = 1'b0;
    case (curKind)
      TX_CTRL_WR: case (idx)
        5'd0: cmdOp = OP_START;
        5'd1: cmdByte = DEV_WR;
        5'd2: cmdByte = al;
        5'd3: cmdByte = curData[15:8];
        5'd4: cmdByte = curData[7:0];
        default: begin cmdOp = OP_STOP; cmdLast = 1'b1; end
      endcase
      TX_CTRL_RD: case (idx)
        5'd0, 5'd3: cmdOp = OP_START;
        5'd1: cmdByte = DEV_WR;
        5'd2: cmdByte = al;
        5'd4: cmdByte = DEV_RD;
        5'd5: cmdOp = OP_RDACK;
        5'd6: cmdOp = OP_RDNACK;
        default: begin cmdOp = OP_STOP; cmdLast = 1'b1; end
      endcase
      TX_DSP_WR, TX_DSP_RD: case (idx)
        5'd0: cmdOp = OP_START;
        5'd1: cmdByte = DEV_WR;
        5'd2: cmdByte = SUB_DSP;
        5'd3: cmdByte = (curKind == TX_DSP_WR) ? 8'hE0 : 8'hC0;
        5'd4, 5'd5: cmdByte = 8'h00;
        5'd6: cmdByte = 8'h01;
        5'd7: cmdByte = ah;
        5'd8: cmdByte = al;
        default: begin
          if (curKind == TX_DSP_WR) begin
            case (idx)
              5'd9:  cmdByte = 8'h00;
              5'd10: cmdByte = {4'h0, curData[19:16]};
              5'd11: cmdByte = curData[15:8];
              5'd12: cmdByte = curData[7:0];
              default: begin cmdOp = OP_STOP; cmdLast = 1'b1; end
            endcase
          end else begin
            case (idx)
              5'd9:  cmdOp = OP_STOP;
              5'd10, 5'd13: cmdOp = OP_START;
              5'd11: cmdByte = DEV_WR;
              5'd12: cmdByte = SUB_DSPRD;
              5'd14: cmdByte = DEV_RD;
              5'd15, 5'd16, 5'd17: cmdOp = OP_RDACK;
              5'd18: cmdOp = OP_RDNACK;
              default: begin cmdOp = OP_STOP; cmdLast = 1'b1; end
            endcase
          end
        end
      endcase
      TX_CODEC_WR: case (idx)
        5'd0: cmdOp = OP_START;
        5'd1: cmdByte = DEV_WR;
        5'd2: cmdByte = SUB_COD;
        5'd3: cmdByte = ah;
        5'd4: cmdByte = al;
        5'd5: cmdByte = curData[15:8];
        5'd6: cmdByte = curData[7:0];
        default: begin cmdOp = OP_STOP; cmdLast = 1'b1; end
      endcase
      default: case (idx)
        5'd0, 5'd6, 5'd9: cmdOp = OP_START;
        5'd1, 5'd7: cmdByte = DEV_WR;
        5'd2: cmdByte = SUB_COD;
        5'd3: cmdByte = ah;
        5'd4: cmdByte = al;
        5'd5: cmdOp = OP_STOP;
        5'd8: cmdByte = SUB_CODRD;
        5'd10: cmdByte = DEV_RD;
        5'd11: cmdOp = OP_RDACK;
        5'd12: cmdOp = OP_RDNACK;
        default: begin cmdOp = OP_STOP; cmdLast = 1'b1; end
      endcase
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      curKind <= TX_CTRL_WR;
      curAddr <= '0;
      curData <= '0;
      idx     <= '0;
      rdShift <= '0;
      txnDone <= 1'b0;
    end else begin
      txnDone <= busy && busCmdDone && cmdLast;
      if (req.start) begin
        busy    <= 1'b1;
        curKind <= req.kind;
        curAddr <= req.addr;
        curData <= req.data;
        idx     <= '0;
        rdShift <= '0;
      end else if (busy && busCmdDone) begin
        idx <= idx + 1'b1;
        if (cmdOp == OP_RDACK || cmdOp == OP_RDNACK)
          rdShift <= {rdShift[15:0], busRdByte};
        if (cmdLast) busy <= 1'b0;
      end
    end
  end

  // Three shifts keep the last three bytes; a fourth pushes out the discarded one.
  assign rdMatch     = (rdShift[19:0] == curData);
  assign busCmdValid = busy;
  assign busCmdOp    = busy ? cmdOp : OP_IDLE;
  assign busCmdByte  = busy ? cmdByte : 8'h00;
endmodule

// File: rtl/codec_boot_ctrl.sv
module codec_boot_ctrl
  import cfgseq_pkg::*;
#(
  parameter int RESET_MS      = 100,
  parameter int SETTLE_MS     = 1000,
  parameter int SHORT_WAIT_MS = 20,
  parameter int LONG_WAIT_MS  = 200,
  parameter int MS_W          = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            modeSel,
  input  logic            txnDone,
  input  logic            rdMatch,
  input  logic            timerExpired,
  output txnreq_t         req,
  output logic            timerLoad,
  output logic [MS_W-1:0] timerMs,
  output logic            chipRst,
  output logic [2:0]      errCode,
  output logic            done
);
  typedef enum logic [2:0] {
    S_BOOT, S_RHOLD, S_SETTLE, S_ISSUE, S_XFER1, S_XFER2, S_WAIT, S_END
  } state_e;

  state_e          state;
  logic            decMode;
  logic [3:0]      stepIdx;
  logic [3:0]      codecK;
  logic [31:0]     codecEnt;
  stepop_e         stOp;
  space_e          stSpace;
  logic [15:0]     stAddr;
  logic [19:0]     stWr, stChk;
  logic [2:0]      stErr;
  logic [MS_W-1:0] stWait;
  logic            stLast;
  logic            goWait, goFail;
  txkind_e         wrKind, rdKind;

  function automatic logic [31:0] codecEntry(input logic dec, input logic [3:0] k);
    case ({dec, k})
      5'h00: return {16'h0000, 16'h2206};
      5'h01: return {16'h0008, 16'h0000};
      5'h02: return {16'h0011, 16'h0000};
      5'h10: return {16'h0000, 16'h2207};
      5'h11: return {16'h0006, 16'h0000};
      5'h12: return {16'h0007, 16'h4000};
      5'h13: return {16'h0008, 16'h0000};
      5'h14: return {16'h000E, 16'h0000};
      5'h15: return {16'h0010, 16'h7F00};
      default: return {16'h0011, 16'h0000};
    endcase
  endfunction

  always_comb begin
    codecK   = stepIdx - 4'd5;
    codecEnt = codecEntry(decMode, codecK);
    stOp     = ST_WRV;
    stSpace  = SP_DSP;
    stAddr   = 16'h07F6;
    stWr     = '0;
    stChk    = '0;
    stErr    = 3'd2;
    stWait   = '0;
    stLast   = 1'b0;
    case (stepIdx)
      4'd0: begin
        stSpace = SP_CTRL; stAddr = 16'h006A; stWr = 20'h08C00;
        stErr = 3'd1; stWait = MS_W'(SHORT_WAIT_MS);
      end
      4'd1: begin
        stWr = decMode ? 20'h0000C : 20'h00040;
        stWait = MS_W'(LONG_WAIT_MS);
      end
      4'd2: begin
        stOp = ST_CHK; stAddr = 16'h07F7;
        stChk = decMode ? 20'h0000C : 20'h00040; stErr = 3'd4;
      end
      4'd3: begin
        stOp = ST_WR; stAddr = 16'h07F1;
        stWr = decMode ? 20'h00011 : 20'h00009; stWait = MS_W'(LONG_WAIT_MS);
      end
      4'd4: begin
        stOp = ST_CHK; stAddr = 16'h07F1;
        stChk = decMode ? 20'h00010 : 20'h00008; stErr = 3'd5;
      end
      default: begin
        stSpace = SP_CODEC; stAddr = codecEnt[31:16];
        stWr = {4'h0, codecEnt[15:0]}; stErr = 3'd3;
        stLast = (stepIdx == (decMode ? 4'd11 : 4'd7));
      end
    endcase
  end

  always_comb begin
    case (stSpace)
      SP_CTRL:  begin wrKind = TX_CTRL_WR;  rdKind = TX_CTRL_RD;  end
      SP_DSP:   begin wrKind = TX_DSP_WR;   rdKind = TX_DSP_RD;   end
      default:  begin wrKind = TX_CODEC_WR; rdKind = TX_CODEC_RD; end
    endcase
  end

  always_comb begin
    goFail = txnDone && !rdMatch &&
             ((state == S_XFER1 && stOp == ST_CHK) || state == S_XFER2);
    goWait = txnDone && !goFail &&
             ((state == S_XFER1 && stOp != ST_WRV) || state == S_XFER2);
    req.start = (state == S_ISSUE) || (state == S_XFER1 && txnDone && stOp == ST_WRV);
    req.kind  = (state == S_ISSUE && stOp != ST_CHK) ? wrKind : rdKind;
    req.addr  = stAddr;
    req.data  = (stOp == ST_CHK) ? stChk : stWr;
    timerLoad = (state == S_BOOT) || (state == S_RHOLD && timerExpired) || goWait;
    case (state)
      S_BOOT:  timerMs = MS_W'(RESET_MS);
      S_RHOLD: timerMs = MS_W'(SETTLE_MS);
      default: timerMs = stWait;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_BOOT;
      stepIdx <= '0;
      errCode <= '0;
      decMode <= modeSel;
    end else begin
      case (state)
        S_BOOT:   state <= S_RHOLD;
        S_RHOLD:  if (timerExpired) state <= S_SETTLE;
        S_SETTLE: if (timerExpired) state <= S_ISSUE;
        S_ISSUE:  state <= S_XFER1;
        S_XFER1, S_XFER2: begin
          if (goFail) begin
            errCode <= stErr;
            state   <= S_END;
          end else if (goWait) begin
            state <= S_WAIT;
          end else if (state == S_XFER1 && txnDone) begin
            state <= S_XFER2;
          end
        end
        S_WAIT: if (timerExpired) begin
          if (stLast) state <= S_END;
          else begin
            stepIdx <= stepIdx + 1'b1;
            state   <= S_ISSUE;
          end
        end
        default: state <= S_END;
      endcase
    end
  end

  assign chipRst = (state == S_BOOT) || (state == S_RHOLD);
  assign done    = (state == S_END);
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import cfgseq_pkg::*;
#(
  parameter int CYC_PER_MS    = 50000,
  parameter int RESET_MS      = 100,
  parameter int SETTLE_MS     = 1000,
  parameter int SHORT_WAIT_MS = 20,
  parameter int LONG_WAIT_MS  = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       modeSel,
  output logic       busCmdValid,
  output logic [2:0] busCmdOp,
  output logic [7:0] busCmdByte,
  input  logic       busCmdDone,
  input  logic [7:0] busRdByte,
  output logic       chipRstOut,
  output logic [2:0] errCode,
  output logic       done
);
  localparam int MS_W = $clog2(RESET_MS + SETTLE_MS + SHORT_WAIT_MS + LONG_WAIT_MS + 1);

  txnreq_t         req;
  logic            txnDone, rdMatch, timerLoad, timerExpired;
  logic [MS_W-1:0] timerMs;

  codec_boot_ctrl #(
    .RESET_MS(RESET_MS), .SETTLE_MS(SETTLE_MS),
    .SHORT_WAIT_MS(SHORT_WAIT_MS), .LONG_WAIT_MS(LONG_WAIT_MS), .MS_W(MS_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel),
    .txnDone(txnDone), .rdMatch(rdMatch), .timerExpired(timerExpired),
    .req(req), .timerLoad(timerLoad), .timerMs(timerMs),
    .chipRst(chipRstOut), .errCode(errCode), .done(done)
  );

  codec_frame_dp u_dp (
    .clk(clk), .rst(rst), .req(req),
    .txnDone(txnDone), .rdMatch(rdMatch),
    .busCmdValid(busCmdValid), .busCmdOp(busCmdOp), .busCmdByte(busCmdByte),
    .busCmdDone(busCmdDone), .busRdByte(busRdByte)
  );

  codec_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst(rst), .load(timerLoad), .loadMs(timerMs), .expired(timerExpired)
  );
endmodule

// File: rtl/codec_boot_seq_chk.sv
module codec_boot_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busCmdValid,
  input logic [2:0] busCmdOp,
  input logic [7:0] busCmdByte,
  input logic       busCmdDone,
  input logic       chipRstOut,
  input logic [2:0] errCode,
  input logic       done
);
  p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
    chipRstOut |-> !busCmdValid);

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busCmdValid && !busCmdDone) |=>
      (busCmdValid && $stable(busCmdOp) && $stable(busCmdByte)));

  p_op_legal_r3: assert property (@(posedge clk) disable iff (rst)
    busCmdValid |-> (busCmdOp >= 3'd1 && busCmdOp <= 3'd5));

  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busCmdValid);

  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(errCode)));

  p_err_halts_r12: assert property (@(posedge clk) disable iff (rst)
    (errCode != 3'd0) |-> done);
endmodule

bind codec_boot_seq codec_boot_seq_chk u_chk (
  .clk(clk), .rst(rst), .busCmdValid(busCmdValid), .busCmdOp(busCmdOp),
  .busCmdByte(busCmdByte), .busCmdDone(busCmdDone), .chipRstOut(chipRstOut),
  .errCode(errCode), .done(done)
);

// File: tb/codec_boot_seq_test.sv
module codec_boot_seq_test;
  localparam int CPM = 2;
  localparam int MAXL = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic       busCmdValid;
  logic [2:0] busCmdOp;
  logic [7:0] busCmdByte;
  logic       busCmdDone = 1'b0;
  logic [7:0] busRdByte = 8'h00;
  logic       chipRstOut;
  logic [2:0] errCode;
  logic       done;

  always #5 clk = ~clk;

  codec_boot_seq #(.CYC_PER_MS(CPM)) uut (
    .clk(clk), .rst(rst), .modeSel(modeSel),
    .busCmdValid(busCmdValid), .busCmdOp(busCmdOp), .busCmdByte(busCmdByte),
    .busCmdDone(busCmdDone), .busRdByte(busRdByte),
    .chipRstOut(chipRstOut), .errCode(errCode), .done(done)
  );

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int rstHigh = 0, rstFall = -1;

  // command log and expected stream
  logic [2:0] logOp [MAXL];
  logic [7:0] logByte [MAXL];
  int         logCyc [MAXL];
  int         logN = 0;
  logic [2:0] expOp [MAXL];
  logic [7:0] expByte [MAXL];
  int         expN = 0;

  // chip model
  logic [7:0]  buffer [16];
  int          nb = 0, rdCnt = 0;
  bit          inFrame = 0;
  logic [7:0]  prevSub = 8'h00;
  logic [15:0] ctrlReg = 0, dspPtr = 0, codecPtr = 0;
  logic [19:0] dspF6 = 0, dspF1 = 0;
  logic [15:0] codecReg [32];
  int          fault = 0;
  logic [15:0] faultAddr = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && chipRstOut) rstHigh <= rstHigh + 1;
    if (!rst && !chipRstOut && rstFall < 0) rstFall <= cyc;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] dspRead(input logic [15:0] a);
    case (a)
      16'h07F6: return dspF6 ^ ((fault == 2) ? 20'h1 : 20'h0);
      16'h07F7: return dspF6 ^ ((fault == 3) ? 20'h1 : 20'h0);
      16'h07F1: return (fault == 4) ? dspF1 : (dspF1 & ~20'h1);
      default:  return 20'h0;
    endcase
  endfunction

  task automatic modelCmd(input logic [2:0] op, input logic [7:0] b, output logic [7:0] rb);
    logic [19:0] v;
    rb = 8'h00;
    case (op)
      3'd1: begin
        prevSub = (inFrame && nb >= 2) ? buffer[1] : 8'h00;
        nb = 0; rdCnt = 0; inFrame = 1;
      end
      3'd3: begin
        if (nb < 16) buffer[nb] = b;
        nb++;
      end
      3'd4, 3'd5: begin
        if (prevSub == 8'h69) begin
          v = dspRead(dspPtr);
          case (rdCnt)
            0: rb = 8'hA5;
            1: rb = {4'hF, v[19:16]};
            2: rb = v[15:8];
            default: rb = v[7:0];
          endcase
        end else begin
          if (prevSub == 8'h6A) v = {4'h0, ctrlReg ^ ((fault == 1) ? 16'h1 : 16'h0)};
          else v = {4'h0, codecReg[codecPtr[4:0]] ^
                   ((fault == 5 && codecPtr == faultAddr) ? 16'h1 : 16'h0)};
          rb = (rdCnt == 0) ? v[15:8] : v[7:0];
        end
        rdCnt++;
      end
      3'd2: begin
        if (nb >= 2 && buffer[0] == 8'h3C) begin
          if (buffer[1] == 8'h6A && nb == 4) ctrlReg = {buffer[2], buffer[3]};
          if (buffer[1] == 8'h68 && nb == 12 && buffer[2] == 8'hE0) begin
            v = {buffer[9][3:0], buffer[10], buffer[11]};
            if ({buffer[6], buffer[7]} == 16'h07F6) dspF6 = v;
            if ({buffer[6], buffer[7]} == 16'h07F1) dspF1 = v;
          end
          if (buffer[1] == 8'h68 && nb == 8 && buffer[2] == 8'hC0) dspPtr = {buffer[6], buffer[7]};
          if (buffer[1] == 8'h6C && nb == 6) codecReg[buffer[3][4:0]] = {buffer[4], buffer[5]};
          if (buffer[1] == 8'h6C && nb == 4) codecPtr = {buffer[2], buffer[3]};
        end
        inFrame = 0;
      end
      default: ;
    endcase
  endtask

  // bus engine: accepts a command one cycle after seeing it, then pulses done
  initial begin
    logic [7:0] rb;
    forever begin
      @(negedge clk);
      if (busCmdValid && !rst) begin
        @(negedge clk);
        if (logN < MAXL) begin
          logOp[logN] = busCmdOp; logByte[logN] = busCmdByte; logCyc[logN] = cyc;
        end
        logN++;
        modelCmd(busCmdOp, busCmdByte, rb);
        busRdByte = rb;
        busCmdDone = 1'b1;
        @(negedge clk);
        busCmdDone = 1'b0;
      end
    end
  end

  task automatic ep(input logic [2:0] op, input logic [7:0] b);
    if (expN < MAXL) begin expOp[expN] = op; expByte[expN] = b; end
    expN++;
  endtask
  task automatic eS();  ep(3'd1, 8'h00); endtask
  task automatic eP();  ep(3'd2, 8'h00); endtask
  task automatic eW(input logic [7:0] b); ep(3'd3, b); endtask
  task automatic ePre(input logic [7:0] c, input logic [15:0] a);
    eS(); eW(8'h3C); eW(8'h68); eW(c); eW(8'h00); eW(8'h00); eW(8'h01);
    eW(a[15:8]); eW(a[7:0]);
  endtask
  task automatic xDspWr(input logic [15:0] a, input logic [19:0] d);
    ePre(8'hE0, a); eW(8'h00); eW({4'h0, d[19:16]}); eW(d[15:8]); eW(d[7:0]); eP();
  endtask
  task automatic xDspRd(input logic [15:0] a);
    ePre(8'hC0, a); eP(); eS(); eW(8'h3C); eW(8'h69); eS(); eW(8'h3D);
    ep(3'd4, 0); ep(3'd4, 0); ep(3'd4, 0); ep(3'd5, 0); eP();
  endtask
  task automatic xCodec(input logic [15:0] a, input logic [15:0] d);
    eS(); eW(8'h3C); eW(8'h6C); eW(a[15:8]); eW(a[7:0]); eW(d[15:8]); eW(d[7:0]); eP();
    eS(); eW(8'h3C); eW(8'h6C); eW(a[15:8]); eW(a[7:0]); eP();
    eS(); eW(8'h3C); eW(8'h6D); eS(); eW(8'h3D); ep(3'd4, 0); ep(3'd5, 0); eP();
  endtask

  function automatic int codecCount(input bit dec);
    return dec ? 7 : 3;
  endfunction
  function automatic logic [31:0] codecItem(input bit dec, input int k);
    logic [15:0] ea [3] = '{16'h0000, 16'h0008, 16'h0011};
    logic [15:0] ed [3] = '{16'h2206, 16'h0000, 16'h0000};
    logic [15:0] da [7] = '{16'h0000, 16'h0006, 16'h0007, 16'h0008, 16'h000E, 16'h0010, 16'h0011};
    logic [15:0] dd [7] = '{16'h2207, 16'h0000, 16'h4000, 16'h0000, 16'h0000, 16'h7F00, 16'h0000};
    return dec ? {da[k], dd[k]} : {ea[k], ed[k]};
  endfunction

  task automatic buildExp(input bit dec, input int failStep);
    logic [19:0] app, io;
    logic [31:0] ce;
    app = dec ? 20'h0C : 20'h40;
    io  = dec ? 20'h11 : 20'h09;
    expN = 0;
    for (int s = 0; s < 5 + codecCount(dec); s++) begin
      case (s)
        0: begin
          eS(); eW(8'h3C); eW(8'h6A); eW(8'h8C); eW(8'h00); eP();
          eS(); eW(8'h3C); eW(8'h6A); eS(); eW(8'h3D); ep(3'd4, 0); ep(3'd5, 0); eP();
        end
        1: begin xDspWr(16'h07F6, app); xDspRd(16'h07F6); end
        2: xDspRd(16'h07F7);
        3: xDspWr(16'h07F1, io);
        4: xDspRd(16'h07F1);
        default: begin ce = codecItem(dec, s - 5); xCodec(ce[31:16], ce[15:0]); end
      endcase
      if (s == failStep) break;
    end
  endtask

  task automatic runCase(input bit dec, input bit flip, input int flt, input logic [15:0] fAddr,
                         input int failStep, input int expErr, input string tag);
    int mism, firstBad, t;
    fault = flt; faultAddr = fAddr;
    ctrlReg = 0; dspF6 = 0; dspF1 = 0; dspPtr = 0; codecPtr = 0; inFrame = 0; nb = 0;
    for (int i = 0; i < 32; i++) codecReg[i] = 16'hFFFF;
    @(negedge clk);
    rst = 1'b1; modeSel = dec;
    repeat (3) @(negedge clk);
    logN = 0; rstHigh = 0; rstFall = -1;
    rst = 1'b0;
    if (flip) begin
      repeat (2) @(negedge clk);
      modeSel = ~dec;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    buildExp(dec, failStep);
    check(done == 1'b1, tag, "done raised", done, 1);
    check(errCode == 3'(expErr), tag, "error code", errCode, expErr);
    check(logN == expN, tag, "command count (halt point)", logN, expN);
    mism = 0; firstBad = -1;
    for (int i = 0; i < logN && i < expN && i < MAXL; i++)
      if (logOp[i] != expOp[i] || (logOp[i] == 3'd3 && logByte[i] != expByte[i])) begin
        mism++;
        if (firstBad < 0) firstBad = i;
      end
    check(mism == 0, tag, "command stream mismatches (first index in expected)", mism, firstBad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(chipRstOut == 1'b1, "R1", "chip reset during reset", chipRstOut, 1);
    check(busCmdValid == 1'b0 && done == 1'b0 && errCode == 3'd0, "R1",
          "idle outputs during reset", {busCmdValid, done, errCode}, 0);

    // clean encode run with timing checks (R1 R4 R5 R6 R7 R8 R9 R10 R11)
    runCase(1'b0, 1'b0, 0, 16'h0, -1, 0, "R8_encode");
    check(rstHigh >= 100*CPM && rstHigh <= 100*CPM + 4, "R1", "chip reset cycles",
          rstHigh, 100*CPM);
    check(logCyc[0] - rstFall >= 1000*CPM && logCyc[0] - rstFall <= 1000*CPM + 12, "R1",
          "settle cycles before first command", logCyc[0] - rstFall, 1000*CPM);
    check(logCyc[14] - logCyc[13] >= 20*CPM && logCyc[14] - logCyc[13] <= 20*CPM + 12, "R11",
          "gap after control step", logCyc[14] - logCyc[13], 20*CPM);
    check(logCyc[48] - logCyc[47] >= 200*CPM && logCyc[48] - logCyc[47] <= 200*CPM + 12, "R9",
          "gap before application check", logCyc[48] - logCyc[47], 200*CPM);
    check(logCyc[82] - logCyc[81] >= 200*CPM && logCyc[82] - logCyc[81] <= 200*CPM + 12, "R10",
          "gap after main I/O write", logCyc[82] - logCyc[81], 200*CPM);

    // clean decode run; junk first byte and high nibble must be dropped (R6)
    runCase(1'b1, 1'b0, 0, 16'h0, -1, 0, "R6_R8_decode");
    // mode change after reset ignored
    runCase(1'b0, 1'b1, 0, 16'h0, -1, 0, "R2_mode_late_change");
    runCase(1'b1, 1'b1, 0, 16'h0, -1, 0, "R2_mode_late_change_dec");

    // single-point faults in each space and check
    runCase(1'b0, 1'b0, 1, 16'h0, 0, 1, "R4_R12_ctrl_fault");
    runCase(1'b1, 1'b0, 2, 16'h0, 1, 2, "R5_R9_dsp_verify_fault");
    runCase(1'b0, 1'b0, 3, 16'h0, 2, 4, "R9_app_running_fault");
    runCase(1'b1, 1'b0, 4, 16'h0, 4, 5, "R10_main_io_fault");

    // sweep codec fault over every codec step of both scripts
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < codecCount(m[0]); k++) begin
        logic [31:0] ce;
        ce = codecItem(m[0], k);
        runCase(m[0], 1'b0, 5, ce[31:16], 5 + k, 3, "R7_R12_codec_fault");
      end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule